// File: doc/BRIEF.md
# Soft-Decision Viterbi Decoder, K=5, Rate 1/2

This block recovers an information bit stream from a rate-1/2 convolutional code with constraint length 5. Each symbol period it accepts one pair of 4-bit soft values, one per coded bit, qualified by a valid strobe. It forms branch metrics for the four possible coded pairs and updates all sixteen trellis path metrics in one cycle. It then stores a vector of sixteen survivor decisions and traces back through the stored history to release one hard bit for every accepted pair.

Decoding is continuous. The stream is never split into blocks and no tail is expected. After reset the decoder assumes that the encoder starts in the all-zero state. Input gaps (valid low) may be any length, and the output keeps a fixed latency counted in accepted pairs, not in clock cycles.

Top module: `viterbi_soft_dec`

## Requirements
- R1: A soft value of 0 means a certain 0 and 15 means a certain 1. The cost of a coded bit is its distance from the hypothesised bit: the value itself for a hypothesised 0, and 15 minus the value for a hypothesised 1. A branch cost is the sum for the two coded bits.
- R2: The coder register holds the new bit and the four bits before it. The first soft value of a pair (`sym_a`) is the coded bit "new XOR three back XOR four back" (generator 19). The second (`sym_b`) is "new XOR one back XOR two back XOR four back" (generator 29).
- R3: Path metrics never wrap. When every metric has its top bit set, the smallest metric is subtracted from all updated metrics, and after that update the smallest metric is below half range.
- R4: The first 34 accepted pairs (traceback depth 30 plus 4) produce no output. Every later accepted pair produces exactly one `dec_valid` pulse in the following clock cycle. `dec_valid` is never high in a cycle that does not follow an accepted pair.
- R5: When every soft value lies on the correct side of the threshold (0..7 for a sent 0, 8..15 for a sent 1), the output stream equals the information stream bit for bit, in order, with the 34-pair delay.
- R6: Cycles with `sym_valid` low leave the path metrics unchanged, produce no output in the next cycle, and do not alter the decoded stream.
- R7: While `rst_n` is low, and in the first cycle after it rises, `dec_valid` is low. After reset, decoding restarts on the assumption that the encoder is in state zero.
- R8: An isolated coded bit that is received with full confidence on the wrong side (for example 15 for a sent 0) is corrected when the nearby soft values are clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | The soft pair on `sym_a`/`sym_b` is accepted this cycle |
| sym_a | input | 4 | Soft value of the first coded bit (generator 19) |
| sym_b | input | 4 | Soft value of the second coded bit (generator 29) |
| dec_valid | output | 1 | `dec_bit` holds a decoded bit |
| dec_bit | output | 1 | Decoded information bit |

## Verification
Three things can happen on one clock edge: metric normalisation, a full add-compare-select update, and the overwrite of the survivor slot that the traceback is reading as its oldest entry. The bench makes them coincide by driving long runs of worst-case soft values (7 for a sent 0, 8 for a sent 1). That raises the minimum metric by 14 per pair and so triggers normalisation about every forty pairs, while the traceback reads every stored slot. The outcome is judged by exact agreement of the decoded stream with the queued information bits, by checking the valid pulse cycle by cycle, and by assertions on metric headroom and on the post-normalisation minimum.

// File: rtl/vd_pkg.sv
// Package vd_pkg
// Shared constants and code definition for the K=5 rate-1/2 soft decoder.
// Assumes: a coder register with the newest bit at the MSB; the trellis state
// holds the four most recent information bits, the newest at the MSB.
package vd_pkg;
    localparam int CONSTR  = 5;
    localparam int ST_W    = CONSTR - 1;
    localparam int N_ST    = 1 << ST_W;
    localparam logic [CONSTR-1:0] GEN_A = 5'd19;
    localparam logic [CONSTR-1:0] GEN_B = 5'd29;

    // Coded pair {a, b} produced by a coder register value
    function automatic logic [1:0] code_pair(input logic [CONSTR-1:0] creg);
        return {^(creg & GEN_A), ^(creg & GEN_B)};
    endfunction
endpackage

// File: rtl/vd_branch_metric.sv
// Module vd_branch_metric
// Computes the four branch costs, one per hypothesised coded pair {a, b}.
// Assumes: unsigned soft values where 0 is a certain 0 and all-ones is a certain 1.
module vd_branch_metric #(
    parameter int SOFT_W = 4,
    localparam int BM_W  = SOFT_W + 1
) (
    input  logic [SOFT_W-1:0]          soft_a,
    input  logic [SOFT_W-1:0]          soft_b,
    output logic [3:0][BM_W-1:0]       cost
);
    localparam logic [SOFT_W-1:0] FULL = '1;

    for (genvar h = 0; h < 4; h++) begin : g_hyp
        localparam logic HYP_A = h[1];
        localparam logic HYP_B = h[0];
        logic [SOFT_W-1:0] dist_a, dist_b;
        // Distance of each soft value from the hypothesised bit
        always_comb begin
            dist_a = HYP_A ? (FULL - soft_a) : soft_a;
            dist_b = HYP_B ? (FULL - soft_b) : soft_b;
        end
        assign cost[h] = {1'b0, dist_a} + {1'b0, dist_b};
    end
endmodule

// File: rtl/vd_acs_array.sv
// Module vd_acs_array
// Add-compare-select over all trellis states in one cycle, with normalisation
// of the metrics by the current minimum, and search for the best state.
// Assumes: the state after a bit is {bit, previous state[top:1]}; the decision
// bit is the LSB of the surviving predecessor. Ties keep the even predecessor.
module vd_acs_array
    import vd_pkg::*;
#(
    parameter int PM_W     = 10,
    parameter int BM_W     = 5,
    parameter int INIT_PEN = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step,
    input  logic [3:0][BM_W-1:0]       cost,
    output logic [N_ST-1:0][PM_W-1:0]  pm,
    output logic [N_ST-1:0]            decision,
    output logic [ST_W-1:0]            best_state
);
    logic [PM_W-1:0] pm_min;
    logic            renorm;

    // Minimum metric and its state, lowest index on ties
    always_comb begin
        pm_min     = pm[0];
        best_state = '0;
        for (int i = 1; i < N_ST; i++) begin
            if (pm[i] < pm_min) begin
                pm_min     = pm[i];
                best_state = ST_W'(i);
            end
        end
    end

    // Normalise only when every metric sits in the upper half of its range
    always_comb begin
        renorm = 1'b1;
        for (int i = 0; i < N_ST; i++) renorm &= pm[i][PM_W-1];
    end

    for (genvar s = 0; s < N_ST; s++) begin : g_state
        localparam logic [ST_W-1:0] NSV  = ST_W'(s);
        localparam int              PRE0 = int'({NSV[ST_W-2:0], 1'b0});
        localparam int              PRE1 = int'({NSV[ST_W-2:0], 1'b1});
        localparam int              HYP0 = int'(code_pair({NSV, 1'b0}));
        localparam int              HYP1 = int'(code_pair({NSV, 1'b1}));
        localparam logic [PM_W-1:0] RST_PM = (s == 0) ? '0 : PM_W'(INIT_PEN);

        logic [PM_W-1:0] cand0, cand1, chosen;
        logic            take1;

        // Candidate metrics from both predecessors and their selection
        always_comb begin
            cand0  = pm[PRE0] + {{(PM_W-BM_W){1'b0}}, cost[HYP0]};
            cand1  = pm[PRE1] + {{(PM_W-BM_W){1'b0}}, cost[HYP1]};
            take1  = cand1 < cand0;
            chosen = take1 ? cand1 : cand0;
        end
        assign decision[s] = take1;

        // Metric register, updated only on an accepted pair
        always_ff @(posedge clk) begin
            if (!rst_n)    pm[s] <= RST_PM;
            else if (step) pm[s] <= renorm ? (chosen - pm_min) : chosen;
        end
    end
endmodule

// File: rtl/vd_traceback.sv
// Module vd_traceback
// Circular store of decision vectors and a traceback unrolled over the full
// depth each cycle. The bit is the decision read at the deepest step.
// Assumes: start_state and dec_in refer to the metrics before this update;
// the slot read as oldest is overwritten at the same edge (old value read).
module vd_traceback
    import vd_pkg::*;
#(
    parameter int TB_LEN = 30,
    localparam int PTR_W = $clog2(TB_LEN),
    localparam int LAT   = TB_LEN + ST_W,
    localparam int CNT_W = $clog2(LAT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic [N_ST-1:0] dec_in,
    input  logic [ST_W-1:0] start_state,
    output logic            out_valid,
    output logic            out_bit
);
    logic [N_ST-1:0]  hist [TB_LEN];
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] fill;
    logic [ST_W-1:0]  walk [TB_LEN];
    logic             deep_bit;

    assign walk[0] = start_state;

    // Write pointer wraps at the traceback depth
    always_ff @(posedge clk) begin
        if (!rst_n)    wr_ptr <= '0;
        else if (step) wr_ptr <= (wr_ptr == PTR_W'(TB_LEN - 1)) ? '0 : wr_ptr + 1'b1;
    end

    // Decision history; contents are ignored until the fill count allows output
    always_ff @(posedge clk) begin
        if (step) hist[wr_ptr] <= dec_in;
    end

    // Count of accepted pairs, saturating at the output latency
    always_ff @(posedge clk) begin
        if (!rst_n)                          fill <= '0;
        else if (step && fill != CNT_W'(LAT)) fill <= fill + 1'b1;
    end

    for (genvar k = 0; k < TB_LEN; k++) begin : g_walk
        logic [PTR_W-1:0] rd_idx;
        logic [N_ST-1:0]  vec;
        logic             dbit;

        // Slot holding the decision vector k+1 pairs back
        always_comb begin
            int t;
            t = int'(wr_ptr) + TB_LEN - 1 - k;
            if (t >= TB_LEN) t = t - TB_LEN;
            rd_idx = PTR_W'(t);
        end
        assign vec  = hist[rd_idx];
        assign dbit = vec[walk[k]];

        if (k < TB_LEN - 1) begin : g_mid
            assign walk[k+1] = {walk[k][ST_W-2:0], dbit};
        end else begin : g_end
            assign deep_bit = dbit;
        end
    end

    // Registered output: one bit per accepted pair once primed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= step && (fill == CNT_W'(LAT));
            if (step) out_bit <= deep_bit;
        end
    end
endmodule

// File: rtl/viterbi_soft_dec.sv
// Module viterbi_soft_dec
// Continuous soft-decision decoder for the K=5, rate-1/2 code (19, 29).
// Assumes: the encoder starts in state zero after reset; inputs may pause.
module viterbi_soft_dec
    import vd_pkg::*;
#(
    parameter int SOFT_W   = 4,
    parameter int TB_LEN   = 30,
    parameter int PM_W     = 10,
    parameter int INIT_PEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    input  logic [SOFT_W-1:0] sym_a,
    input  logic [SOFT_W-1:0] sym_b,
    output logic              dec_valid,
    output logic              dec_bit
);
    localparam int BM_W = SOFT_W + 1;

    logic [3:0][BM_W-1:0]      cost;
    logic [N_ST-1:0][PM_W-1:0] pm_all;
    logic [N_ST-1:0]           decision;
    logic [ST_W-1:0]           best_state;

    vd_branch_metric #(.SOFT_W(SOFT_W)) u_bm (
        .soft_a (sym_a),
        .soft_b (sym_b),
        .cost   (cost)
    );

    vd_acs_array #(.PM_W(PM_W), .BM_W(BM_W), .INIT_PEN(INIT_PEN)) u_acs (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (sym_valid),
        .cost       (cost),
        .pm         (pm_all),
        .decision   (decision),
        .best_state (best_state)
    );

    vd_traceback #(.TB_LEN(TB_LEN)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (sym_valid),
        .dec_in      (decision),
        .start_state (best_state),
        .out_valid   (dec_valid),
        .out_bit     (dec_bit)
    );
endmodule

// File: rtl/vd_checker.sv
// Module vd_checker
// Property checks on metric headroom, normalisation and output timing.
// Assumes: bound into viterbi_soft_dec; sees the metric bank by name.
module vd_checker
    import vd_pkg::*;
#(
    parameter int PM_W   = 10,
    parameter int SOFT_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sym_valid,
    input logic                      dec_valid,
    input logic [N_ST-1:0][PM_W-1:0] pm_all
);
    localparam int BM_MAX = 2 * ((1 << SOFT_W) - 1);
    localparam logic [PM_W-1:0] HEAD = PM_W'((1 << PM_W) - 2 * BM_MAX);
    localparam logic [PM_W-1:0] HALF = PM_W'(1 << (PM_W - 1));

    logic [PM_W-1:0] mx, mn;
    logic            all_hi;

    // Extremes of the metric bank, computed on their own
    always_comb begin
        mx = '0;
        mn = '1;
        all_hi = 1'b1;
        for (int i = 0; i < N_ST; i++) begin
            if (pm_all[i] > mx) mx = pm_all[i];
            if (pm_all[i] < mn) mn = pm_all[i];
            all_hi &= (pm_all[i] >= HALF);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) mx < HEAD); // R3
    AST_NORM_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (sym_valid && all_hi) |=> (mn < HALF)); // R3
    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n) dec_valid |-> $past(sym_valid)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sym_valid |=> $stable(pm_all)); // R6
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !dec_valid); // R7
endmodule

bind viterbi_soft_dec vd_checker #(.PM_W(PM_W), .SOFT_W(SOFT_W)) u_vd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .dec_valid (dec_valid),
    .pm_all    (pm_all)
);

// File: tb/test_viterbi_soft_dec.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver encodes and queues bits, the monitor pops and compares.
module test_viterbi_soft_dec;
    localparam int LAT = 34;   // R4: traceback depth 30 plus 4

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic [3:0] sym_a = '0;
    logic [3:0] sym_b = '0;
    logic       dec_valid, dec_bit;

    int n_cmp = 0;
    int n_bad = 0;
    bit exp_q[$];
    logic [3:0] enc = '0;
    int  accepted = 0;
    bit  pend_iv = 0;
    int  pend_cnt = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    viterbi_soft_dec i_viterbi_soft_dec (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
        .sym_a(sym_a), .sym_b(sym_b), .dec_valid(dec_valid), .dec_bit(dec_bit)
    );

    // Soft value for a coded bit under a noise mode (0 clean, 1 random, 2 worst)
    function automatic logic [3:0] soften(input bit c, input int mode);
        logic [3:0] m;
        case (mode)
            1:       m = 4'($urandom_range(0, 7));
            2:       m = 4'd7;
            default: m = 4'd0;
        endcase
        return c ? 4'd15 - m : m;
    endfunction

    // Encode one bit (R2), queue it and present the soft pair
    task automatic send(input bit b, input int mode, input bit flip);
        bit ca, cb;
        ca = b ^ enc[1] ^ enc[0];
        cb = b ^ enc[3] ^ enc[2] ^ enc[0];
        enc = {b, enc[3:1]};
        exp_q.push_back(b);
        @(posedge clk); #1;
        sym_valid = 1'b1;
        sym_a = flip ? soften(~ca, 0) : soften(ca, mode);
        sym_b = soften(cb, mode);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            sym_valid = 1'b0;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: per-cycle valid timing (R4, R6) and scoreboard pop (R5)
    always @(negedge clk) begin
        if (!rst_n) begin
            pend_iv  = 0;
            accepted = 0;
            pend_cnt = 0;
        end else begin
            bit exp_ov;
            exp_ov = pend_iv && (pend_cnt >= LAT);
            if (dec_valid != exp_ov) check(0, "R4 dec_valid timing", int'(dec_valid), int'(exp_ov));
            if (dec_valid) begin
                if (exp_q.size() == 0) check(0, "R5 output with empty queue", 1, 0);
                else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(dec_bit == e, "R5 decoded bit", int'(dec_bit), int'(e));
                end
            end
            pend_iv  = sym_valid;
            pend_cnt = accepted;
            if (sym_valid) accepted++;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(100000 * 5);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(dec_valid == 1'b0, "R7 reset out valid", int'(dec_valid), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(dec_valid == 1'b0, "R7 first cycle after reset", int'(dec_valid), 0);

        // R1 R5: clean soft values, back to back
        for (int i = 0; i < 300; i++) send(1'($urandom_range(0, 1)), 0, 0);
        // R1 R5 R6: random sub-threshold noise with random gaps
        for (int i = 0; i < 800; i++) begin
            send(1'($urandom_range(0, 1)), 1, 0);
            idle($urandom_range(0, 3));
        end
        idle(5);
        check(dec_valid == 1'b0, "R6 no output while idle", int'(dec_valid), 0);
        // R3: worst-case values 7/8, normalisation coincides with updates
        for (int i = 0; i < 1500; i++) send(1'($urandom_range(0, 1)), 2, 0);
        // R8: isolated fully wrong coded bit every 40 pairs
        for (int i = 0; i < 600; i++) send(1'($urandom_range(0, 1)), 0, (i % 40) == 20);
        idle(3);
        check(exp_q.size() == LAT, "R4 pairs held back", exp_q.size(), LAT);

        // R7: reset in mid-stream, decoder restarts from state zero
        @(posedge clk); #1;
        rst_n = 1'b0;
        exp_q.delete();
        enc = '0;
        idle(3);
        check(dec_valid == 1'b0, "R7 reset mid-stream", int'(dec_valid), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 400; i++) send(1'($urandom_range(0, 1)), 1, 0);
        idle(3);
        check(exp_q.size() == LAT, "R7 R4 pairs held back after restart", exp_q.size(), LAT);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule